// File: doc/BRIEF.md
# Task-Completion Interrupt Coalescer

This block sits beside a command-queue engine and cuts the interrupt rate seen by software. The engine reports each finished task as a one-cycle completion pulse with a flag. A set flag asks for an interrupt right away. A clear flag lets the completion join a batch. Batched completions are counted. The coalesced interrupt fires when the count reaches a programmed threshold, or when a timeout runs out. The timeout starts with the first batched completion and advances once every 1024 clocks.

Software controls the block through one 32-bit register. A write strobe carries the write data, and the read data is always visible. The register holds an enable bit, a threshold field, a timeout field and a sticky status bit. Each of the two numeric fields has its own update-enable bit, so a single write can change one field without disturbing the other. A command bit clears the batch state and the status bit.

Top module: `irq_coalescer`

## Requirements
- R1: While enable (bit 31) is 0, no coalesced interrupt is produced. The completion counter and timeout timer are held at zero.
- R2: Status (bit 20, read-only) becomes 1 on every completion whose flag is 0, whatever the enable. Only the reset command clears it; an interrupt firing leaves it set.
- R3: Writing with bit 16 set clears the completion counter, the timeout timer, its 1024-clock prescaler, the timer-running state and the status bit. A batched completion in that same cycle is discarded.
- R4: The threshold (bits 12:8) takes bits 12:8 of the write data only when bit 15 of that same write is 1. Otherwise it keeps its value.
- R5: The timeout value (bits 6:0) takes bits 6:0 of the write data only when bit 7 of that same write is 1. Otherwise it keeps its value.
- R6: With a nonzero threshold N, irq_out goes high for one cycle in the cycle after the Nth batched completion. A threshold of 0 disables this trigger.
- R7: With a nonzero timeout T, irq_out goes high for one cycle in the cycle after the clock edge that falls 1024*T edges after the first batched completion was sampled. A timeout of 0 disables this trigger.
- R8: When either trigger fires, the counter, timer, prescaler and running state return to zero, so the next batch needs a full threshold or a full timeout again.
- R9: A completion whose flag is 1 makes irq_out high in the next cycle. It leaves the counter, the timer and the status unchanged.
- R10: Bits 30:21, 19:17 and 16:13, and bit 7, always read 0. All stored fields are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| done_pulse | input | 1 | One-cycle task-completion pulse |
| done_irq_now | input | 1 | Completion asks for an immediate interrupt |
| irq_out | output | 1 | Interrupt pulse (coalesced or immediate) |

## Verification
A wrong counter value shows up as an interrupt pulse one or more completions early or late. It becomes visible in the cycle after the completion that should have reached the threshold. A prescaler or timer fault moves the timeout pulse by whole 1024-cycle steps, or by a single cycle for an off-by-one. The bench therefore compares irq_out against its model on every clock across full timeout windows. A field-gating or status error appears at once in the read data, which is compared on every cycle as well.

// File: rtl/irq_coalescer.sv
module irq_coalescer #(
  parameter int PRESCALE = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        done_pulse,
  input  logic        done_irq_now,
  output logic        irq_out
);
  localparam int PW = $clog2(PRESCALE);
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

  logic          en, status, running, irq_q;
  logic [4:0]    thr, cnt;
  logic [6:0]    tov, tmr;
  logic [PW-1:0] pre;

  wire clr     = reg_we & reg_wdata[16];
  wire batched = done_pulse & ~done_irq_now;
  wire urgent  = done_pulse & done_irq_now;
  wire tick    = running && (pre == PRE_LAST);

  wire [5:0] cnt_inc = {1'b0, cnt} + 6'd1;
  wire [7:0] tmr_inc = {1'b0, tmr} + 8'd1;

  wire cnt_hit = batched && (thr != 5'd0) && (cnt_inc >= {1'b0, thr});
  wire tmr_hit = tick && (tov != 7'd0) && (tmr_inc >= {1'b0, tov});
  wire fire    = en && !clr && (cnt_hit || tmr_hit);
  wire flush   = clr || !en || fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en  <= 1'b0;
      thr <= '0;
      tov <= '0;
    end else if (reg_we) begin
      en <= reg_wdata[31];
      if (reg_wdata[15]) thr <= reg_wdata[12:8];
      if (reg_wdata[7])  tov <= reg_wdata[6:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      status <= 1'b0;
    else if (clr)    status <= 1'b0;
    else if (batched) status <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      cnt     <= '0;
      tmr     <= '0;
      pre     <= '0;
      running <= 1'b0;
    end else begin
      if (batched && cnt != 5'd31) cnt <= cnt_inc[4:0];
      if (running) begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick && tmr != 7'd127) tmr <= tmr_inc[6:0];
      end
      if (batched) running <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= fire || urgent;
  end

  assign irq_out   = irq_q;
  assign reg_rdata = {en, 10'd0, status, 7'd0, thr, 1'b0, tov};

  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !urgent |=> !irq_out);
  assert_disabled_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt == 5'd0 && !running);
  assert_clear_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == 5'd0 && tmr == 7'd0 && !running && !status);
  assert_thr_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_wdata[15]) |=> $stable(thr));
  assert_tov_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_wdata[7]) |=> $stable(tov));
  assert_fresh_batch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> cnt == 5'd0 && tmr == 7'd0 && !running && pre == '0);
  assert_urgent_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    urgent |=> irq_out);
  assert_urgent_no_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    urgent && en && !clr && !tmr_hit |=> $stable(cnt));
endmodule

// File: tb/irq_coalescer_test.sv
module irq_coalescer_test;
  localparam int PRE = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, done_pulse = 1'b0, done_irq_now = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq_out;

  int total = 0, bad = 0, irq_seen = 0;

  irq_coalescer #(.PRESCALE(PRE)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .done_pulse(done_pulse), .done_irq_now(done_irq_now),
    .irq_out(irq_out));

  always #4 clk = ~clk;

  int m_en, m_thr, m_tov, m_st, m_cnt, m_tmr, m_pre, m_run, m_irq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_thr = 0; m_tov = 0; m_st = 0;
      m_cnt = 0; m_tmr = 0; m_pre = 0; m_run = 0; m_irq = 0;
    end else begin
      bit clr, bat, urg, fire;
      clr = reg_we && reg_wdata[16];
      bat = done_pulse && !done_irq_now;
      urg = done_pulse && done_irq_now;
      fire = 0;
      if (m_en != 0 && !clr) begin
        if (bat && m_thr != 0 && m_cnt + 1 >= m_thr) fire = 1;
        if (m_run != 0 && m_pre == PRE - 1 && m_tov != 0 && m_tmr + 1 >= m_tov) fire = 1;
      end
      m_irq = (fire || urg) ? 1 : 0;
      if (clr || m_en == 0 || fire) begin
        m_cnt = 0; m_tmr = 0; m_pre = 0; m_run = 0;
      end else begin
        if (m_run != 0) begin
          if (m_pre == PRE - 1) begin
            m_pre = 0;
            if (m_tmr < 127) m_tmr++;
          end else m_pre++;
        end
        if (bat) begin
          if (m_cnt < 31) m_cnt++;
          m_run = 1;
        end
      end
      if (clr) m_st = 0;
      else if (bat) m_st = 1;
      if (reg_we) begin
        m_en = reg_wdata[31];
        if (reg_wdata[15]) m_thr = int'(reg_wdata[12:8]);
        if (reg_wdata[7])  m_tov = int'(reg_wdata[6:0]);
      end
    end
  end

  function automatic logic [31:0] model_rd();
    return {m_en[0], 10'd0, m_st[0], 7'd0, 5'(m_thr), 1'b0, 7'(m_tov)};
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (irq_out !== m_irq[0]) begin
        bad++;
        $display("FAIL per-cycle irq_out (R6 R7 R9): got %0b expected %0b at %0t", irq_out, m_irq[0], $time);
      end
      total++;
      if (reg_rdata !== model_rd()) begin
        bad++;
        $display("FAIL per-cycle readback (R2 R4 R5 R10): got %h expected %h", reg_rdata, model_rd());
      end
      if (irq_out) irq_seen++;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk); #1; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); #1; reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic comp(logic now);
    @(negedge clk); #1; done_pulse = 1'b1; done_irq_now = now;
    @(negedge clk); #1; done_pulse = 1'b0; done_irq_now = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog: got hung expected finished");
    finish_run();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    #1; rst_n = 1'b1;
    idle(1);
    chk("R10 reset readback", reg_rdata, 32'h0);

    wr(32'h8001_8380 | 32'h0000_0300);
    chk("R10 R4 threshold 3 set, write-only bits read 0", reg_rdata, 32'h8000_0300);
    wr(32'h8000_0500);
    chk("R4 threshold kept without bit 15", reg_rdata[12:8], 32'd3);

    base = irq_seen;
    comp(1'b0); comp(1'b0); idle(3);
    chk("R6 no irq after two of three", irq_seen - base, 0);
    comp(1'b0); idle(1);
    chk("R6 irq after third completion", irq_seen - base, 1);
    chk("R2 status set and kept after firing", reg_rdata[20], 1);

    base = irq_seen;
    comp(1'b0); comp(1'b0); idle(2);
    chk("R8 fresh batch, no early irq", irq_seen - base, 0);
    comp(1'b1); idle(1);
    chk("R9 immediate irq", irq_seen - base, 1);
    comp(1'b0); idle(1);
    chk("R9 immediate did not disturb count", irq_seen - base, 2);

    wr(32'h8001_0000);
    chk("R3 clear command clears status", reg_rdata[20], 0);

    wr(32'h8000_8082);
    chk("R5 timeout 2 set, threshold 0", reg_rdata, 32'h8000_0002);
    base = irq_seen;
    comp(1'b0);
    idle(2047);
    chk("R7 no irq before 2048 edges", irq_seen - base, 0);
    idle(1);
    chk("R7 irq at 2048 edges", irq_seen - base, 1);
    idle(2100);
    chk("R8 R7 timer not rearmed after fire", irq_seen - base, 1);

    wr(32'h8000_0005);
    chk("R5 timeout kept without bit 7", reg_rdata[6:0], 32'd2);

    wr(32'h0000_8181);
    base = irq_seen;
    comp(1'b0); comp(1'b0); idle(3000);
    chk("R1 disabled: no coalesced irq", irq_seen - base, 0);
    chk("R2 status set while disabled", reg_rdata[20], 1);

    wr(32'h0001_0000);
    @(negedge clk); #1;
    reg_we = 1'b1; reg_wdata = 32'h8001_8100; done_pulse = 1'b1; done_irq_now = 1'b0;
    @(negedge clk); #1;
    reg_we = 1'b0; reg_wdata = '0; done_pulse = 1'b0;
    chk("R3 clear wins over same-cycle completion", reg_rdata[20], 0);
    base = irq_seen;
    comp(1'b0); idle(1);
    chk("R3 R6 threshold 1 fires on next completion", irq_seen - base, 1);

    idle(2);
    finish_run();
  end
endmodule